// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 16-bit program counter of an 8-bit microcontroller core. It also computes the address of the next instruction to fetch. On each cycle the decoder supplies four things: the length in bytes of the current instruction, a jump kind, the operand fields that belong to that kind, and the current data pointer and accumulator values. From these the unit forms the next address combinationally. When `step_i` is high it loads that address into the PC at the clock edge.

There are five ways to form the next address:
- plain fall-through;
- a short jump by a signed 8-bit displacement;
- a jump to an 11-bit offset inside the current 2 KiB page;
- a full 16-bit jump;
- a jump to the data pointer plus the unsigned accumulator.

Separately, the unit drives a code-memory read address for table lookups. That address is either the following instruction's address plus the accumulator, or the data pointer plus the accumulator. Deciding whether a conditional jump is taken, call and return stacking, and the memory itself all belong to other blocks.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the PC reads 0x0000 until the first step.
- R2: With `kind_i` = 0 (sequential), or any unused code 5 to 7, the next address is PC + `len_i`.
- R3: With `kind_i` = 1 (relative), the next address is PC + `len_i` + the sign-extended `rel_i`, reaching 127 bytes forward or 128 bytes back from the following instruction.
- R4: With `kind_i` = 2 (page), the next address takes bits 15:11 from PC + `len_i` and bits 10:0 from `abs_i`.
- R5: With `kind_i` = 3 (long), the next address is `long_i`.
- R6: With `kind_i` = 4 (indexed), the next address is `dptr_i` + zero-extended `acc_i`.
- R7: When `step_i` is low, the PC keeps its value.
- R8: With `lk_src_i` = 0, `lk_addr_o` = PC + `len_i` + `acc_i`. For example, PC 0x1002, length 1 and accumulator 5 give 0x1008.
- R9: With `lk_src_i` = 1, `lk_addr_o` = `dptr_i` + `acc_i`. For example, 0x4000 with accumulator 5 gives 0x4005.
- R10: `npc_o` shows the next address in the same cycle, and a step loads exactly that value into the PC on the next edge.
- R11: All 16-bit sums wrap modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Load the next address into the PC |
| kind_i | input | 3 | Jump kind: 0 seq, 1 rel, 2 page, 3 long, 4 indexed |
| len_i | input | 2 | Byte length of the current instruction |
| rel_i | input | 8 | Signed relative displacement |
| abs_i | input | 11 | In-page target offset |
| long_i | input | 16 | Full target address |
| dptr_i | input | 16 | Data pointer value |
| acc_i | input | 8 | Accumulator value, unsigned |
| lk_src_i | input | 1 | Lookup base: 0 next PC, 1 data pointer |
| pc_o | output | 16 | Current program counter |
| npc_o | output | 16 | Next instruction address |
| lk_addr_o | output | 16 | Table-lookup code-memory address |

## Verification
The assertions assume that the decoder presents stable, known values on `kind_i`, `len_i`, `step_i` and the operand fields throughout each cycle. They also assume that operand fields not used by the selected kind may hold any value. The bench changes inputs only on the falling edge and fills the unused fields with random values. This keeps the inputs within those assumptions while still showing that the unused fields are ignored. The bench applies directed vectors at the displacement limits and at the 0xFFFF wrap, and crosses page boundaries. It then applies a long random run, in which every kind and both lookup sources are compared against a behavioural model on every clock.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned PAGE_W = 11;
  localparam int unsigned LEN_W  = 2;

  typedef enum logic [2:0] {
    JK_SEQ  = 3'd0,
    JK_REL  = 3'd1,
    JK_PAGE = 3'd2,
    JK_LONG = 3'd3,
    JK_IDX  = 3'd4
  } jump_kind_e;
endpackage

// File: rtl/pcu_add.sv
// Adds a narrow operand, zero- or sign-extended, to a wide base.
module pcu_add #(
  parameter int unsigned AW     = 16,
  parameter int unsigned OW     = 8,
  parameter bit          SIGNED = 1'b0
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] op_i,
  output logic [AW-1:0] sum_o
);
  localparam int unsigned EXT_W = AW - OW;
  logic [AW-1:0] op_ext;

  generate
    if (SIGNED) begin : g_sext
      assign op_ext = {{EXT_W{op_i[OW-1]}}, op_i};
    end else begin : g_zext
      assign op_ext = {{EXT_W{1'b0}}, op_i};
    end
  endgenerate

  assign sum_o = base_i + op_ext;
endmodule

// File: rtl/pcu_target_sel.sv
module pcu_target_sel
  import pcu_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned PW = 11
) (
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] seq_i,
  input  logic [AW-1:0] rel_i,
  input  logic [PW-1:0] page_off_i,
  input  logic [AW-1:0] long_i,
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] npc_o
);
  always_comb begin
    unique case (kind_i)
      JK_REL:  npc_o = rel_i;
      JK_PAGE: npc_o = {seq_i[AW-1:PW], page_off_i};
      JK_LONG: npc_o = long_i;
      JK_IDX:  npc_o = idx_i;
      default: npc_o = seq_i;
    endcase
  end
endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] d_i,
  output logic [AW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned PW = PAGE_W,
  parameter int unsigned LW = LEN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [2:0]    kind_i,
  input  logic [LW-1:0] len_i,
  input  logic [DW-1:0] rel_i,
  input  logic [PW-1:0] abs_i,
  input  logic [AW-1:0] long_i,
  input  logic [AW-1:0] dptr_i,
  input  logic [DW-1:0] acc_i,
  input  logic          lk_src_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o,
  output logic [AW-1:0] lk_addr_o
);
  logic [AW-1:0] pc_q, seq_addr, rel_addr, idx_addr, lk_pc_addr, lk_base;

  pcu_pc_reg #(.AW(AW)) u_pc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(step_i), .d_i(npc_o), .q_o(pc_q)
  );

  pcu_add #(.AW(AW), .OW(LW), .SIGNED(1'b0)) u_seq (
    .base_i(pc_q), .op_i(len_i), .sum_o(seq_addr)
  );

  pcu_add #(.AW(AW), .OW(DW), .SIGNED(1'b1)) u_rel (
    .base_i(seq_addr), .op_i(rel_i), .sum_o(rel_addr)
  );

  pcu_add #(.AW(AW), .OW(DW), .SIGNED(1'b0)) u_idx (
    .base_i(dptr_i), .op_i(acc_i), .sum_o(idx_addr)
  );

  // lookup base mux ahead of a dedicated adder keeps jump path independent
  assign lk_base = lk_src_i ? dptr_i : seq_addr;

  pcu_add #(.AW(AW), .OW(DW), .SIGNED(1'b0)) u_lk (
    .base_i(lk_base), .op_i(acc_i), .sum_o(lk_pc_addr)
  );

  pcu_target_sel #(.AW(AW), .PW(PW)) u_sel (
    .kind_i(kind_i), .seq_i(seq_addr), .rel_i(rel_addr), .page_off_i(abs_i),
    .long_i(long_i), .idx_i(idx_addr), .npc_o(npc_o)
  );

  assign pc_o      = pc_q;
  assign lk_addr_o = lk_pc_addr;
endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          step_i,
  input logic [2:0]    kind_i,
  input logic [AW-1:0] long_i,
  input logic [PW-1:0] abs_i,
  input logic [AW-1:0] dptr_i,
  input logic [DW-1:0] acc_i,
  input logic          lk_src_i,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] npc_o,
  input logic [AW-1:0] lk_addr_o
);
  // R1
  always @(posedge clk_i) if (!rst_ni) reset_pc_chk: assert (pc_o == '0);

  // R7
  hold_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o));

  // R10
  step_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> pc_o == $past(npc_o));

  // R5
  long_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == 3'd3 |-> npc_o == long_i);

  // R4
  page_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == 3'd2 |-> npc_o[PW-1:0] == abs_i);

  // R9
  lk_dptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_src_i |-> lk_addr_o == AW'(dptr_i + {{(AW-DW){1'b0}}, acc_i}));
endmodule

bind pc_next_unit pc_next_unit_chk #(.AW(AW), .DW(DW), .PW(PW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .kind_i(kind_i),
  .long_i(long_i), .abs_i(abs_i), .dptr_i(dptr_i), .acc_i(acc_i),
  .lk_src_i(lk_src_i), .pc_o(pc_o), .npc_o(npc_o), .lk_addr_o(lk_addr_o)
);

// File: tb/tb_pc_next_unit.sv
module tb_pc_next_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        step;
  logic [2:0]  kind;
  logic [1:0]  len;
  logic [7:0]  rel, acc;
  logic [10:0] abs_off;
  logic [15:0] long_a, dptr;
  logic        lk_src;
  logic [15:0] pc, npc, lk_addr;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  int model_pc = 0;

  pc_next_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .kind_i(kind), .len_i(len),
    .rel_i(rel), .abs_i(abs_off), .long_i(long_a), .dptr_i(dptr), .acc_i(acc),
    .lk_src_i(lk_src), .pc_o(pc), .npc_o(npc), .lk_addr_o(lk_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_next(int p);
    int s;
    s = (p + int'(len)) % 65536;
    case (kind)
      3'd1: return (s + int'($signed(rel)) + 65536) % 65536;
      3'd2: return (s / 2048) * 2048 + int'(abs_off);
      3'd3: return int'(long_a);
      3'd4: return (int'(dptr) + int'(acc)) % 65536;
      default: return s;
    endcase
  endfunction

  function automatic int exp_lk(int p);
    if (lk_src) return (int'(dptr) + int'(acc)) % 65536;
    return (p + int'(len) + int'(acc)) % 65536;
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %04h expected %04h", req, act, exp);
    end
  endtask

  task automatic apply(string req, bit st, logic [2:0] k, logic [1:0] l,
                       logic [7:0] r, logic [10:0] ab, logic [15:0] lg,
                       logic [15:0] dp, logic [7:0] ac, bit src);
    int e;
    @(negedge clk);
    step = st; kind = k; len = l; rel = r; abs_off = ab; long_a = lg;
    dptr = dp; acc = ac; lk_src = src;
    #1;
    e = exp_next(model_pc);
    check({req, " npc R10"}, int'(npc), e);
    check({req, " lookup R8/R9"}, int'(lk_addr), exp_lk(model_pc));
    @(posedge clk);
    if (st) model_pc = e;
    #1;
    check({req, " pc"}, int'(pc), model_pc);
  endtask

  task automatic go_to(logic [15:0] a);
    apply("R5 long", 1, 3'd3, $urandom, $urandom, $urandom, a, $urandom, $urandom, 0);
  endtask

  initial begin
    step = 0; kind = 0; len = 0; rel = 0; abs_off = 0; long_a = 0;
    dptr = 0; acc = 0; lk_src = 0;
    #(CLK_PERIOD*2 + 2);
    check("R1 reset", int'(pc), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", int'(pc), 0);

    apply("R2 seq len3", 1, 3'd0, 2'd3, 8'h55, 11'h7ff, 16'hbeef, 16'h1234, 8'h9, 0);
    apply("R2 unused kind 6", 1, 3'd6, 2'd2, 8'h80, 11'h123, 16'h4444, 16'h0, 8'h0, 0);
    apply("R7 hold", 0, 3'd3, 2'd1, 8'h0, 11'h0, 16'hdead, 16'h0, 8'h0, 0);
    check("R7 hold pc", int'(pc), 5);
    go_to(16'h1000);
    apply("R3 rel +127", 1, 3'd1, 2'd2, 8'h7f, 11'h0, 16'h0, 16'h0, 8'h0, 0);
    check("R3 fwd max", int'(pc), 16'h1081);
    apply("R3 rel -128", 1, 3'd1, 2'd2, 8'h80, 11'h0, 16'h0, 16'h0, 8'h0, 0);
    check("R3 back max", int'(pc), 16'h1003);
    go_to(16'h17fe);
    apply("R4 page cross", 1, 3'd2, 2'd2, 8'h0, 11'h005, 16'h0, 16'h0, 8'h0, 0);
    check("R4 page from next", int'(pc), 16'h1805);
    apply("R6 indexed", 1, 3'd4, 2'd1, 8'h0, 11'h0, 16'h0, 16'h2000, 8'hff, 0);
    check("R6 dptr+acc", int'(pc), 16'h20ff);
    go_to(16'h1002);
    apply("R8 lookup pc", 0, 3'd0, 2'd1, 8'h0, 11'h0, 16'h0, 16'h0, 8'h5, 0);
    check("R8 0x1008", int'(lk_addr), 16'h1008);
    apply("R9 lookup dptr", 0, 3'd0, 2'd1, 8'h0, 11'h0, 16'h0, 16'h4000, 8'h5, 1);
    check("R9 0x4005", int'(lk_addr), 16'h4005);
    go_to(16'hffff);
    apply("R11 wrap seq", 1, 3'd0, 2'd1, 8'h0, 11'h0, 16'h0, 16'h0, 8'h0, 0);
    check("R11 wrap to 0", int'(pc), 0);
    apply("R11 rel wrap", 1, 3'd1, 2'd1, 8'hf0, 11'h0, 16'h0, 16'h0, 8'h0, 0);
    check("R11 rel under", int'(pc), 16'hfff1);
    apply("R11 idx wrap", 1, 3'd4, 2'd1, 8'h0, 11'h0, 16'h0, 16'hfff0, 8'h20, 1);

    for (int i = 0; i < 3000; i++)
      apply("rand", $urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)), $urandom,
            $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule